// File: doc/BRIEF.md
# Programmable Logic Output Cell Row

This block is the output stage of a small sum-of-products programmable logic device. It holds a row of output cells, eight by default. Each cell ORs its group of product terms from the AND array and can invert the result. It then sends that value to its pin either straight through or through a flip-flop. It also chooses what drives the pin enable and what value goes back into the AND array as feedback.

How a cell behaves depends on two mode bits shared by the whole row and one mode bit of its own. These three bits select one of five legal behaviours:

- a registered output;
- a combinational I/O in a device that uses registers;
- a dedicated combinational output;
- a dedicated input;
- a combinational I/O in a device with no registers.

When a cell is an I/O, its last product term stops feeding the OR and drives the pin enable instead.

The two cells at the ends of the row route feedback differently. In a device with no registers, they carry the levels of the output-enable pin and the clock pin back into the AND array. Each cell also has its own polarity bit. All flip-flops clear on reset, and they can be loaded directly for testing.

The pin is modelled as three separate signals: data out, output enable and pin level in.

Top module: `pal_cell_row`

## Requirements
- R1: With shared bits (mode_a, mode_b) and local bit cell_sel, the legal codes are:
  - 010: registered output;
  - 011: registered-device I/O;
  - 100: dedicated output;
  - 101: dedicated input;
  - 111: non-registered I/O.

  Any other code makes cfg_err high, pin_oe low and fb low for that cell.
- R2: In registered output mode, the OR of all product terms is captured on the rising clock edge. pin_out and fb show the flip-flop, and pin_oe equals the inverse of oe_pin_n.
- R3: In both I/O modes, only the lower PT_PER_CELL-1 terms are ORed, the top term of the cell drives pin_oe, and fb is the cell's own pin_in. The edge cells in a non-registered device are the exception (see R6).
- R4: In dedicated output mode, all terms are ORed and pin_oe is 1. A non-edge cell's fb is its adjacent pin: cells with index at most N_CELLS/2-1 use pin_in[i+1], and the others use pin_in[i-1]. The two middle cells give fb = 0.
- R5: In dedicated input mode, pin_oe is 0 and a non-edge cell's fb is its adjacent pin, as in R4. The middle cells also follow this rule.
- R6: The edge cells choose their feedback using mode_a instead of mode_b:
  - with mode_a = 1 and a legal code, cell 0 feeds back the level of oe_pin_n and cell N_CELLS-1 feeds back clk_pin_lvl;
  - with mode_a = 0, cell_sel picks the flip-flop (0) or the own pin (1).
- R7: When pol is 1, the OR result passes through unchanged. When pol is 0, it is inverted. The inversion is applied before the flip-flop, so registered and combinational outputs invert alike.
- R8: A low rst_n clears every flip-flop at once, and it overrides preload.
- R9: When pl_en is high at a rising edge, every flip-flop loads pl_val instead of its OR result, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset of all cell registers |
| mode_a | input | 1 | Shared mode bit: 1 means no registers in use |
| mode_b | input | 1 | Shared mode bit paired with cell_sel |
| cell_sel | input | N_CELLS | Local mode bit per cell |
| pol | input | N_CELLS | Polarity per cell, 1 = true output |
| pterm | input | N_CELLS*PT_PER_CELL | Product terms, cell i in slice i*PT_PER_CELL |
| oe_pin_n | input | 1 | Active-low shared output-enable pin level |
| clk_pin_lvl | input | 1 | Data level of the clock pin for non-registered use |
| pin_in | input | N_CELLS | Level seen on each cell's pin |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | N_CELLS | Test preload value |
| pin_out | output | N_CELLS | Data driven toward each pin |
| pin_oe | output | N_CELLS | Driver enable for each pin |
| fb | output | N_CELLS | Feedback into the AND array |
| cfg_err | output | N_CELLS | Illegal mode code flag per cell |

## Verification
The bench first checks the corner cases by hand:
- Cells that are driving their own pin enable from the top product term. A design that kept that term in the OR would drive a 1 when only that term is set.
- The middle cells in dedicated output mode. A design that forgot them would feed back the neighbouring pin instead of 0.
- The edge cells when mode_a is 1. A design steered by mode_b would return its own pin or the flip-flop instead of oe_pin_n or clk_pin_lvl.

It then runs a long pseudo-random sequence that mixes legal and illegal codes, polarity and preload. It also drops reset while preload is active, which catches a design that put preload ahead of reset.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;

   typedef enum logic [2:0] {
      CM_REGOUT  = 3'd0,
      CM_IO_REG  = 3'd1,
      CM_COMBOUT = 3'd2,
      CM_INPUT   = 3'd3,
      CM_IO_NREG = 3'd4,
      CM_BAD     = 3'd5
   } cell_mode_e;

   function automatic logic mode_is_io(input cell_mode_e m);
      return (m == CM_IO_REG) || (m == CM_IO_NREG);
   endfunction

endpackage

// File: rtl/pal_cell_decode.sv
module pal_cell_decode
   import pal_cell_pkg::*;
(
   input  logic       mode_a,
   input  logic       mode_b,
   input  logic       cell_sel,
   output cell_mode_e mode,
   output logic       bad
);
   always_comb begin
      unique case ({mode_a, mode_b, cell_sel})
         3'b010:  mode = CM_REGOUT;
         3'b011:  mode = CM_IO_REG;
         3'b100:  mode = CM_COMBOUT;
         3'b101:  mode = CM_INPUT;
         3'b111:  mode = CM_IO_NREG;
         default: mode = CM_BAD;
      endcase
   end
   assign bad = (mode == CM_BAD);
endmodule

// File: rtl/pal_cell_sum.sv
module pal_cell_sum #(
   parameter int PT_W = 8
) (
   input  logic [PT_W-1:0] pt,
   input  logic            io_mode,
   input  logic            pol,
   output logic            d,
   output logic            oe_term
);
   localparam int LOW_W = PT_W - 1;

   logic or_all;
   logic or_low;
   logic raw;

   always_comb begin
      or_all  = |pt;
      or_low  = |pt[LOW_W-1:0];
      raw     = io_mode ? or_low : or_all;
      d       = raw ^ ~pol;
      oe_term = pt[PT_W-1];
   end
endmodule

// File: rtl/pal_cell_ff.sv
module pal_cell_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic pl_en,
   input  logic pl_val,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (pl_en) q <= pl_val;
      else            q <= d;
   end

   p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pl_en |=> (q == $past(pl_val)));

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pl_en |=> (q == $past(d)));
endmodule

// File: rtl/pal_cell_fbsel.sv
module pal_cell_fbsel #(
   parameter bit IS_EDGE      = 1'b0,
   parameter bit QUIET_IN_OUT = 1'b0
) (
   input  logic mode_a,
   input  logic mode_b,
   input  logic cell_sel,
   input  logic bad,
   input  logic q,
   input  logic own_pin,
   input  logic adj_pin,
   input  logic alt_pin,
   output logic fb
);
   logic sel_local;
   logic far_src;

   always_comb begin
      sel_local = IS_EDGE ? ~mode_a : mode_b;
      if (IS_EDGE)                         far_src = alt_pin;
      else if (QUIET_IN_OUT && !cell_sel)  far_src = 1'b0;
      else                                 far_src = adj_pin;
      if (bad)            fb = 1'b0;
      else if (sel_local) fb = cell_sel ? own_pin : q;
      else                fb = far_src;
   end
endmodule

// File: rtl/pal_cell.sv
module pal_cell
   import pal_cell_pkg::*;
#(
   parameter int PT_W         = 8,
   parameter bit IS_EDGE      = 1'b0,
   parameter bit QUIET_IN_OUT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_a,
   input  logic            mode_b,
   input  logic            cell_sel,
   input  logic            pol,
   input  logic [PT_W-1:0] pt,
   input  logic            glb_oe_n,
   input  logic            own_pin,
   input  logic            adj_pin,
   input  logic            alt_pin,
   input  logic            pl_en,
   input  logic            pl_val,
   output logic            pin_out,
   output logic            pin_oe,
   output logic            fb,
   output logic            cfg_err
);
   cell_mode_e mode;
   logic       bad;
   logic       d;
   logic       oe_term;
   logic       q;

   pal_cell_decode u_dec (
      .mode_a(mode_a), .mode_b(mode_b), .cell_sel(cell_sel),
      .mode(mode), .bad(bad)
   );

   pal_cell_sum #(.PT_W(PT_W)) u_sum (
      .pt(pt), .io_mode(mode_is_io(mode)), .pol(pol),
      .d(d), .oe_term(oe_term)
   );

   pal_cell_ff u_ff (
      .clk(clk), .rst_n(rst_n), .d(d), .pl_en(pl_en), .pl_val(pl_val), .q(q)
   );

   pal_cell_fbsel #(.IS_EDGE(IS_EDGE), .QUIET_IN_OUT(QUIET_IN_OUT)) u_fb (
      .mode_a(mode_a), .mode_b(mode_b), .cell_sel(cell_sel), .bad(bad),
      .q(q), .own_pin(own_pin), .adj_pin(adj_pin), .alt_pin(alt_pin), .fb(fb)
   );

   always_comb begin
      pin_out = (mode == CM_REGOUT) ? q : d;
      unique case (mode)
         CM_REGOUT:             pin_oe = ~glb_oe_n;
         CM_IO_REG, CM_IO_NREG: pin_oe = oe_term;
         CM_COMBOUT:            pin_oe = 1'b1;
         default:               pin_oe = 1'b0;
      endcase
      cfg_err = bad;
   end

   p_bad_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!pin_oe && !fb));

   p_reg_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CM_REGOUT) |-> (pin_out == q && pin_oe == !glb_oe_n));

   p_io_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_is_io(mode) |-> (pin_oe == pt[PT_W-1]));

   p_comb_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CM_COMBOUT) |-> pin_oe);

   p_input_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CM_INPUT) |-> !pin_oe);

   p_pol_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == CM_COMBOUT) && (pt == '0)) |-> (pin_out == !pol));

   if (IS_EDGE) begin : g_edge_chk
      p_edge_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_a && !cfg_err) |-> (fb == alt_pin));
   end
endmodule

// File: rtl/pal_cell_row.sv
module pal_cell_row #(
   parameter int N_CELLS     = 8,
   parameter int PT_PER_CELL = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           mode_a,
   input  logic                           mode_b,
   input  logic [N_CELLS-1:0]             cell_sel,
   input  logic [N_CELLS-1:0]             pol,
   input  logic [N_CELLS*PT_PER_CELL-1:0] pterm,
   input  logic                           oe_pin_n,
   input  logic                           clk_pin_lvl,
   input  logic [N_CELLS-1:0]             pin_in,
   input  logic                           pl_en,
   input  logic [N_CELLS-1:0]             pl_val,
   output logic [N_CELLS-1:0]             pin_out,
   output logic [N_CELLS-1:0]             pin_oe,
   output logic [N_CELLS-1:0]             fb,
   output logic [N_CELLS-1:0]             cfg_err
);
   localparam int MID_LO = N_CELLS/2 - 1;
   localparam int MID_HI = N_CELLS/2;
   localparam int LAST   = N_CELLS - 1;

   initial begin
      if (N_CELLS < 4 || (N_CELLS % 2) != 0)
         $fatal(1, "pal_cell_row: N_CELLS must be even and at least 4");
      if (PT_PER_CELL < 2)
         $fatal(1, "pal_cell_row: PT_PER_CELL must be at least 2");
   end

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      logic adj;
      logic alt;

      if (i <= MID_LO) begin : g_up
         assign adj = pin_in[i+1];
      end else begin : g_dn
         assign adj = pin_in[i-1];
      end

      if (i == 0) begin : g_alt_oe
         assign alt = oe_pin_n;
      end else if (i == LAST) begin : g_alt_ck
         assign alt = clk_pin_lvl;
      end else begin : g_alt_none
         assign alt = 1'b0;
      end

      pal_cell #(
         .PT_W        (PT_PER_CELL),
         .IS_EDGE     ((i == 0) || (i == LAST)),
         .QUIET_IN_OUT((i == MID_LO) || (i == MID_HI))
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode_a  (mode_a),
         .mode_b  (mode_b),
         .cell_sel(cell_sel[i]),
         .pol     (pol[i]),
         .pt      (pterm[i*PT_PER_CELL +: PT_PER_CELL]),
         .glb_oe_n(oe_pin_n),
         .own_pin (pin_in[i]),
         .adj_pin (adj),
         .alt_pin (alt),
         .pl_en   (pl_en),
         .pl_val  (pl_val[i]),
         .pin_out (pin_out[i]),
         .pin_oe  (pin_oe[i]),
         .fb      (fb[i]),
         .cfg_err (cfg_err[i])
      );
   end
endmodule

// File: tb/pal_cell_row_tb.sv
module pal_cell_row_tb;
   localparam int N  = 8;
   localparam int PT = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic            mode_a, mode_b;
   logic [N-1:0]    cell_sel, pol, pin_in, pl_val;
   logic [N*PT-1:0] pterm;
   logic            oe_pin_n, clk_pin_lvl, pl_en;
   logic [N-1:0]    pin_out, pin_oe, fb, cfg_err;

   pal_cell_row #(.N_CELLS(N), .PT_PER_CELL(PT)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
      .cell_sel(cell_sel), .pol(pol), .pterm(pterm), .oe_pin_n(oe_pin_n),
      .clk_pin_lvl(clk_pin_lvl), .pin_in(pin_in), .pl_en(pl_en), .pl_val(pl_val),
      .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb), .cfg_err(cfg_err)
   );

   typedef struct packed {
      logic [N-1:0] out;
      logic [N-1:0] oe;
      logic [N-1:0] fbk;
      logic [N-1:0] err;
   } exp_t;

   exp_t   exp_q[$];
   string  tag_q[$];
   int     n_chk  = 0;
   int     n_fail = 0;
   logic [N-1:0] model_q = '0;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Reference of one cell, written from the requirements
   task automatic model_cell(input int i, input logic a, input logic b, input logic [N-1:0] sel,
                             input logic [N-1:0] pl, input logic [N*PT-1:0] pt,
                             input logic [N-1:0] pin, input logic oen, input logic ckl,
                             input logic ple, input logic [N-1:0] plv,
                             output logic qn, output logic o, output logic e,
                             output logic f, output logic er);
      logic [PT-1:0] p;
      logic reg_m, io_m, comb_m, in_m, bad, d, adj;
      p      = pt[i*PT +: PT];
      reg_m  = ({a, b, sel[i]} == 3'b010);
      io_m   = ({a, b, sel[i]} == 3'b011) || ({a, b, sel[i]} == 3'b111);
      comb_m = ({a, b, sel[i]} == 3'b100);
      in_m   = ({a, b, sel[i]} == 3'b101);
      bad    = !(reg_m || io_m || comb_m || in_m);
      d      = (io_m ? |p[PT-2:0] : |p) ^ ~pl[i];
      qn     = ple ? plv[i] : d;
      o      = reg_m ? qn : d;
      e      = reg_m ? ~oen : io_m ? p[PT-1] : comb_m;
      adj    = (i <= N/2-1) ? pin[i+1] : pin[i-1];
      er     = bad;
      if (bad) f = 1'b0;
      else if (i == 0 || i == N-1)
         f = a ? ((i == 0) ? oen : ckl) : (sel[i] ? pin[i] : qn);
      else if (b) f = sel[i] ? pin[i] : qn;
      else if (comb_m && (i == N/2-1 || i == N/2)) f = 1'b0;
      else f = adj;
   endtask

   task automatic drive(input logic a, input logic b, input logic [N-1:0] sel,
                        input logic [N-1:0] pl, input logic [N*PT-1:0] pt,
                        input logic [N-1:0] pin, input logic oen, input logic ckl,
                        input logic ple, input logic [N-1:0] plv, input string tag);
      exp_t x;
      @(negedge clk);
      mode_a = a; mode_b = b; cell_sel = sel; pol = pl; pterm = pt;
      pin_in = pin; oe_pin_n = oen; clk_pin_lvl = ckl; pl_en = ple; pl_val = plv;
      for (int i = 0; i < N; i++) begin
         logic qn, o, e, f, er;
         model_cell(i, a, b, sel, pl, pt, pin, oen, ckl, ple, plv, qn, o, e, f, er);
         model_q[i] = qn;
         x.out[i] = o & e;
         x.oe[i]  = e;
         x.fbk[i] = f;
         x.err[i] = er;
      end
      exp_q.push_back(x);
      tag_q.push_back(tag);
   endtask

   // Monitor: samples one cycle result after each capture edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t x;
            string t;
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {8'h0, pin_out & x.oe, pin_oe, fb, cfg_err},
                  {8'h0, x.out, x.oe, x.fbk, x.err});
         end
      end
   end

   function automatic logic [31:0] lcg(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #200000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end

   initial begin
      logic [31:0] s;
      rst_n = 1'b0; mode_a = 1'b0; mode_b = 1'b1; cell_sel = '0; pol = '1;
      pterm = '1; oe_pin_n = 1'b0; clk_pin_lvl = 1'b0; pin_in = '0;
      pl_en = 1'b1; pl_val = '1;
      repeat (3) @(posedge clk);
      #1;
      // R8: reset clears registers even with preload requested
      check("R8 reset state", {24'h0, pin_out}, 32'h0);
      check("R8 reset oe", {24'h0, pin_oe}, 32'hff);
      @(negedge clk);
      rst_n = 1'b1;
      pl_en = 1'b0;

      // R2: registered capture, pattern of single terms
      drive(0, 1, 8'h00, 8'hff, 64'h0080_0000_0004_0001, 8'h00, 0, 0, 0, 8'h00, "R2 capture");
      drive(0, 1, 8'h00, 8'hff, 64'h0000_1000_0000_0200, 8'h33, 1, 0, 0, 8'h00, "R2 oe pin high");
      // R7: inversion before register
      drive(0, 1, 8'h00, 8'h00, 64'h0000_1000_0000_0200, 8'h00, 0, 0, 0, 8'h00, "R7 inverted reg");
      drive(1, 0, 8'h00, 8'h0f, 64'h0, 8'h00, 0, 0, 0, 8'h00, "R7 comb polarity");
      // R9: preload wins over capture
      drive(0, 1, 8'h00, 8'hff, {N*PT{1'b1}}, 8'h00, 0, 0, 1, 8'ha5, "R9 preload");
      drive(1, 0, 8'h00, 8'hff, {N*PT{1'b1}}, 8'h00, 0, 0, 1, 8'h3c, "R9 preload any mode");
      // R3: top term only enables, lower terms ORed, fb own pin
      drive(0, 1, 8'hff, 8'hff, {N{8'h80}}, 8'h96, 0, 0, 0, 8'h00, "R3 io enable term");
      drive(1, 1, 8'hff, 8'hff, {N{8'h01}}, 8'h69, 1, 1, 0, 8'h00, "R3 io nonreg");
      // R4: dedicated output, adjacency and quiet middle cells
      drive(1, 0, 8'h00, 8'hff, 64'h1, 8'h5a, 1, 0, 0, 8'h00, "R4 dedicated out");
      drive(1, 0, 8'h00, 8'hff, 64'h0, 8'ha5, 0, 1, 0, 8'h00, "R4 adjacency");
      // R5: dedicated input
      drive(1, 0, 8'hff, 8'hff, {N*PT{1'b1}}, 8'h18, 0, 1, 0, 8'h00, "R5 input");
      // R6: edge feedback steered by mode_a
      drive(1, 1, 8'hff, 8'hff, 64'h0, 8'h81, 1, 0, 0, 8'h00, "R6 edge alt pins");
      drive(0, 1, 8'h7e, 8'hff, 64'h0, 8'hff, 1, 1, 0, 8'h00, "R6 edge reg device");
      // R1: illegal codes
      drive(0, 0, 8'h0f, 8'hff, {N*PT{1'b1}}, 8'hff, 0, 1, 0, 8'h00, "R1 illegal 00x");
      drive(1, 1, 8'h0f, 8'hff, {N*PT{1'b1}}, 8'hff, 0, 1, 0, 8'h00, "R1 mixed 11x");

      s = 32'h1234_5678;
      for (int k = 0; k < 400; k++) begin
         logic a, b, ple;
         logic [N-1:0] sel, pl, pin, plv;
         logic [N*PT-1:0] pt;
         logic [2:0] g;
         string t;
         s = lcg(s); g = s[20:18] % 3'd5;
         a = (g == 3) || (g == 4) || (g == 1 && s[3]);
         b = (g == 0) || (g == 4) || (g == 2 && s[4]);
         sel = s[31:24]; pl = s[15:8];
         s = lcg(s); pin = s[31:24]; ple = (s[7:0] < 8'd20); plv = s[23:16];
         for (int w = 0; w < 2; w++) begin
            logic [31:0] m1, m2, m3;
            s = lcg(s); m1 = s; s = lcg(s); m2 = s; s = lcg(s); m3 = s;
            pt[w*32 +: 32] = m1 & m2 & m3;
         end
         s = lcg(s);
         t = (g == 0) ? "R2 random registered" : (g == 3) ? "R4 random nonreg" :
             (g == 4) ? "R6 random io nonreg" : (g == 1) ? "R1 random bad" : "R3 random";
         drive(a, b, sel, pl, pt, pin, s[5], s[9], ple, plv, t);
      end
      repeat (3) @(posedge clk);

      // R8: reset mid-run overrides preload, asynchronously
      drive(0, 1, 8'h00, 8'hff, {N*PT{1'b1}}, 8'h00, 0, 0, 0, 8'h00, "R2 load ones");
      repeat (2) @(posedge clk);
      @(negedge clk);
      pl_en = 1'b1; pl_val = 8'hff; rst_n = 1'b0;
      #1;
      check("R8 async clear", {24'h0, pin_out}, 32'h0);
      @(posedge clk);
      #1;
      check("R8 over preload", {24'h0, pin_out}, 32'h0);
      report();
      $finish;
   end
endmodule